// File: doc/BRIEF.md
# Bit-Knowledge Bound Sharpener

This unit tightens a 64-bit bound so that it agrees with what is known about the individual bits of a variable. Two masks describe that knowledge. In `may_zero`, a 1 means the bit is allowed to be 0. In `may_one`, a 1 means the bit is allowed to be 1. A bit that is clear in `may_zero` is forced to one. A bit that is clear in `may_one` is forced to zero. Callers must keep `may_zero | may_one` all ones, so that no bit is asked to be both 0 and 1.

In lower mode (`mode` = 0) the unit returns the smallest value at or above `bound` that honours every forced bit. In upper mode (`mode` = 1) it returns the largest value at or below `bound` that honours them. Upper mode reuses the lower-mode datapath: it complements the bound and swaps the roles of the two masks. When no honouring value exists in 64 bits, the unit raises `out_empty` and returns the input bound unchanged.

Requests arrive with `in_valid`. The result, the empty flag and `out_valid` are registered and appear one clock later.

Top module: `bound_sharpener`

## Requirements
- R1: `out_valid` is 1 in the cycle after each cycle in which `in_valid` is 1, and 0 otherwise.
- R2: In lower mode (`mode`=0), a `bound` that already honours the masks is returned unchanged, with `out_empty`=0.
- R3: In lower mode, when a value exists that is at least `bound` and honours the masks (bit set only where `may_one` is 1, bit clear only where `may_zero` is 1), `out_bound` is the smallest such value and `out_empty`=0.
- R4: In lower mode, with only bit 0 forced to zero and `bound`=5, `out_bound` is 6.
- R5: In upper mode (`mode`=1), `out_bound` is the largest honouring value that is at most `bound`, with `out_empty`=0 when such a value exists.
- R6: When no honouring value exists on the requested side of `bound`, `out_empty`=1 and `out_bound` equals the input `bound`.
- R7: When `in_valid` is 0, `out_bound` and `out_empty` keep their previous values.
- R8: After reset, `out_valid`, `out_bound` and `out_empty` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 1 | 0: raise a lower bound, 1: lower an upper bound |
| bound | input | 64 | Bound to sharpen |
| may_zero | input | 64 | 1 = bit may be 0 |
| may_one | input | 64 | 1 = bit may be 1 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_bound | output | 64 | Sharpened bound |
| out_empty | output | 1 | No honouring value on the requested side |

## Verification
Every result (`out_bound`, `out_empty` and `out_valid`) is due exactly one rising edge after the cycle that carries its request. The bench drives each request on a falling edge and drops `in_valid` on the next falling edge. It reads the outputs at that falling edge, half a period after the capturing edge. One falling edge later it checks that `out_valid` has returned to 0 and that the registered values are unchanged. The expected bounds come from a bench model that enumerates every candidate bit position. That model does not use the carry trick.

// File: rtl/bound_sharpener.sv
module bound_sharpener #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         mode,
  input  logic [W-1:0] bound,
  input  logic [W-1:0] may_zero,
  input  logic [W-1:0] may_one,
  output logic         out_valid,
  output logic [W-1:0] out_bound,
  output logic         out_empty
);
  localparam int IW = $clog2(W);

  logic [W-1:0] lo, zz, oo, mis, tgt, top, pick, res_l, res;
  logic [IW-1:0] idx;
  logic         empty;

  assign lo  = mode ? ~bound  : bound;
  assign zz  = mode ? may_one  : may_zero;
  assign oo  = mode ? may_zero : may_one;
  assign mis = (~lo & ~zz) | (lo & ~oo);
  assign tgt = ~lo & oo;

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++)
      if (mis[i]) idx = IW'(i);
  end

  assign top   = (mis != '0) ? ({{(W-1){1'b0}}, 1'b1} << idx) : '0;
  assign pick  = tgt & (~tgt + top);
  assign empty = (mis != '0) && (pick == '0);
  assign res_l = (mis == '0) ? lo : ((lo & (~pick + 1'b1)) | pick | ~zz);
  assign res   = empty ? bound : (mode ? ~res_l : res_l);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bound <= '0;
      out_empty <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_bound <= res;
        out_empty <= empty;
      end
    end
  end
endmodule

// File: rtl/bound_sharpener_chk.sv
module bound_sharpener_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         mode,
  input logic [W-1:0] bound,
  input logic [W-1:0] may_zero,
  input logic [W-1:0] may_one,
  input logic         out_valid,
  input logic [W-1:0] out_bound,
  input logic         out_empty
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_FITS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_empty || (((out_bound & ~$past(may_one)) == '0) &&
                                ((~out_bound & ~$past(may_zero)) == '0)))); // R3
  AST_LOWER_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode) |=> out_bound >= $past(bound)); // R3
  AST_UPPER_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode) |=> out_bound <= $past(bound)); // R5
  AST_EMPTY_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid |=> (!out_empty || out_bound == $past(bound)))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_bound) && $stable(out_empty))); // R7
endmodule

bind bound_sharpener bound_sharpener_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bound_sharpener.sv
module tb_bound_sharpener;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        mode = 1'b0;
  logic [63:0] bound = '0, may_zero = '1, may_one = '1;
  logic        out_valid, out_empty;
  logic [63:0] out_bound;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bound_sharpener dut (.*);

  function automatic bit fits(logic [63:0] v, logic [63:0] z, logic [63:0] o);
    return ((v & ~o) == '0) && ((~v & ~z) == '0);
  endfunction

  function automatic logic [64:0] ref_low(logic [63:0] lo, logic [63:0] z, logic [63:0] o);
    logic [63:0] best, cand, hi, below;
    bit found;
    if (fits(lo, z, o)) return {1'b0, lo};
    found = 0; best = '0;
    for (int i = 0; i < 64; i++) begin
      hi    = ~((64'd2 << i) - 64'd1);
      below = (64'd1 << i) - 64'd1;
      if (!lo[i] && o[i] && ((lo & hi & ~o) == '0) && ((~lo & hi & ~z) == '0)) begin
        cand = (lo & hi) | (64'd1 << i) | (~z & below);
        if (!found || cand < best) best = cand;
        found = 1;
      end
    end
    return found ? {1'b0, best} : {1'b1, lo};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(string req, bit m, logic [63:0] b, logic [63:0] z, logic [63:0] o);
    logic [64:0] r;
    logic [63:0] exp_b;
    bit exp_e;
    if (!m) r = ref_low(b, z, o);
    else begin
      r = ref_low(~b, o, z);
      if (!r[64]) r[63:0] = ~r[63:0];
    end
    exp_e = r[64];
    exp_b = exp_e ? b : r[63:0];
    @(negedge clk);
    in_valid = 1; mode = m; bound = b; may_zero = z; may_one = o;
    @(negedge clk);
    in_valid = 0; bound = ~b;
    check("R1", 64'(out_valid), 64'd1);
    check(req, out_bound, exp_b);
    check(exp_e ? "R6" : req, 64'(out_empty), 64'(exp_e));
    @(negedge clk);
    check("R1", 64'(out_valid), 64'd0);
    check("R7", out_bound, exp_b);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, f, d, b, z, o;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8", 64'(out_valid), 64'd0);
    check("R8", out_bound, 64'd0);
    check("R8", 64'(out_empty), 64'd0);
    rst_n = 1;
    run("R4", 0, 64'd5, '1, ~64'd1);
    check("R4", out_bound, 64'd6);
    run("R2", 0, 64'd6, '1, ~64'd1);
    run("R2", 0, 64'h1234, '1, '1);
    run("R5", 1, 64'd5, '1, ~64'd1);
    check("R5", out_bound, 64'd4);
    run("R6", 0, '1, '1, ~64'd1);
    run("R6", 1, 64'd0, ~64'd1, '1);
    run("R3", 0, 64'h8000_0000_0000_0000, ~64'h1, '1);
    run("R3", 0, 64'h00F0, ~64'h0100, ~64'h0080);
    for (int k = 0; k < 400; k++) begin
      a = {$urandom, $urandom};
      f = {$urandom, $urandom} & {$urandom, $urandom};
      if (k % 3 == 0) f = f & {$urandom, $urandom};
      d = {$urandom, $urandom};
      z = ~(f & d);
      o = ~(f & ~d);
      b = (k % 5 == 0) ? (a >> (k % 64)) : a;
      run((k % 2) ? "R5" : "R3", k % 2, b, z, o);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule